// File: doc/BRIEF.md
# Boot-Page Sequential NAND Fetcher

This block lets a processor execute its first instructions straight out of a NAND flash device, before any software driver exists. When reset is released it puts the device into read mode at row zero on its own. It issues one command strobe and then a fixed number of address strobes, all carrying zero. It waits out the device's busy period, then signals that it is ready to serve fetches.

A processor read that decodes to the fixed boot window returns the next bytes of that single page. The bytes are packed little-endian into one response beat. The page can only be consumed in order. The column advances one byte per device read strobe. The row is never touched again, and the column never returns to zero. Out-of-order reads and reads past the end of the page are answered with all-ones data and a flag. Software ends boot mode with a one-cycle pulse, after which the block goes quiet until the next reset.

Top module: `nand_boot_fetcher`

## Requirements
- R1: No strobe is driven while reset is held. In the first cycle after reset release the block asserts `nand_cle` for one cycle with `nand_io_out` = 0x00. It then asserts `nand_ale` for ADDR_CYCLES consecutive single cycles, each with `nand_io_out` = 0x00. At most one of `nand_cle`, `nand_ale` and `nand_re` is high in any cycle.
- R2: After the last address strobe the block waits WB_CYCLES cycles, then waits for `nand_ready` = 1. Until then `req_ready` stays 0 and `nand_re` is never asserted.
- R3: A request is taken only when `req_addr[31:16]` equals 0x1FC0. Any other request produces no response, no read strobe and no column change.
- R4: An accepted request whose low 16 address bits equal the current column issues BEAT_BYTES read strobes. It returns the bytes with the lowest column in `rsp_data[7:0]`, and the column grows by BEAT_BYTES.
- R5: An accepted request whose low 16 address bits differ from the current column returns `rsp_err` = 1 and all-ones data. It issues no read strobe and leaves the column unchanged.
- R6: During boot the block issues no further command or address strobes. The column never decreases and never exceeds PAGE_BYTES.
- R7: A request at the current column when fewer than BEAT_BYTES bytes remain returns all-ones data with `rsp_err` = 0 and issues no read strobe. It sets `overrun`, which stays 1 until reset.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. It rises 1 + 2*BEAT_BYTES clock edges after the accepting edge for a data fetch, and 1 edge after it for a rejected one. `req_ready` is 0 while `rsp_valid` is 1.
- R9: After boot mode ends, `boot_mode` is 0. No strobe, `req_ready` or `rsp_valid` is asserted until the next reset.
- R10: A `sw_boot_off` pulse that arrives while a fetch is in progress lets that fetch finish with correct data. `boot_mode` stays 1 through the response cycle and falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_boot_off | input | 1 | One-cycle pulse from software ending boot mode |
| boot_mode | output | 1 | 1 while boot fetching is active |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Request byte address |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | Response beat valid (one cycle) |
| rsp_data | output | 8*BEAT_BYTES | Response data, little-endian |
| rsp_err | output | 1 | Response was for a non-sequential address |
| overrun | output | 1 | Sticky: a fetch ran past the page end |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_re | output | 1 | Read strobe, data expected on nand_io_in next cycle |
| nand_io_out | output | 8 | Command/address byte |
| nand_io_in | input | 8 | Read data from the device |
| nand_ready | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench builds the block with a 32-byte page and 4-byte beats, keeping ADDR_CYCLES = 4 and WB_CYCLES = 2. Eight fetches then drain the page, so the end-of-page boundary and the sticky overrun flag are reached within a short run. The multi-lane beat packing is exercised with every byte order check. A device model holds ready low for ten cycles after the address phase, which makes the ready wait observable. A second reset then repeats the start-up sequence and ends boot mode in the middle of a fetch.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

   typedef enum logic [3:0] {
      ST_RST,
      ST_CMD,
      ST_ADDR,
      ST_WB,
      ST_WAIT,
      ST_IDLE,
      ST_RD,
      ST_CAP,
      ST_RSP,
      ST_OFF
   } nbf_state_e;

   localparam logic [7:0] NBF_READ_CMD  = 8'h00;
   localparam logic [7:0] NBF_ADDR_BYTE = 8'h00;
   localparam int         NBF_CNT_W     = 4;

endpackage

// File: rtl/nbf_window_decode.sv
module nbf_window_decode #(
   parameter int          ADDR_W   = 32,
   parameter int          WIN_W    = 16,
   parameter logic [15:0] WIN_BASE = 16'h1FC0,
   parameter int          COL_W    = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [COL_W-1:0]  col,
   output logic              hit,
   output logic              bad_seq
);
   localparam int OFF_W = ADDR_W - WIN_W;

   logic [WIN_W-1:0] upper;
   logic [OFF_W-1:0] offset;

   assign upper   = addr[ADDR_W-1 -: WIN_W];
   assign offset  = addr[OFF_W-1:0];
   assign hit     = (upper == WIN_BASE[WIN_W-1:0]);
   assign bad_seq = (offset != OFF_W'(col));

endmodule

// File: rtl/nbf_column_ctr.sv
module nbf_column_ctr #(
   parameter int PAGE_BYTES = 2048,
   parameter int BEAT_BYTES = 4,
   parameter int COL_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [COL_W-1:0] col,
   output logic             past_end
);
   localparam logic [COL_W:0]   LIMIT = (COL_W+1)'(PAGE_BYTES);
   localparam logic [COL_W:0]   STEP  = (COL_W+1)'(BEAT_BYTES);
   localparam logic [COL_W-1:0] LAST  = COL_W'(PAGE_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)
         col <= '0;
      else if (adv && (col != LAST))
         col <= col + COL_W'(1);
   end

   assign past_end = ({1'b0, col} + STEP) > LIMIT;

   assert_col_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      col >= $past(col));
   assert_col_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      col <= LAST);
   assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (col == $past(col)) || (col == $past(col) + COL_W'(1)));

endmodule

// File: rtl/nbf_beat_pack.sv
module nbf_beat_pack #(
   parameter int BEAT_BYTES = 4,
   parameter int BI_W       = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill,
   input  logic                    cap,
   input  logic [BI_W-1:0]         bidx,
   input  logic [7:0]              din,
   output logic [8*BEAT_BYTES-1:0] word
);
   generate
      if (BEAT_BYTES == 1) begin : g_single
         logic unused_bidx;
         assign unused_bidx = ^bidx;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word <= '0;
            else if (fill)
               word <= '1;
            else if (cap)
               word <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)
               word <= '0;
            else if (fill)
               word <= '1;
            else if (cap) begin
               for (int i = 0; i < BEAT_BYTES; i++)
                  if (bidx == BI_W'(i))
                     word[8*i +: 8] <= din;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nbf_sequencer.sv
module nbf_sequencer
   import nbf_pkg::*;
#(
   parameter int ADDR_CYCLES = 4,
   parameter int WB_CYCLES   = 2,
   parameter int BEAT_BYTES  = 4,
   parameter int BI_W        = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nand_ready,
   input  logic            sw_off,
   input  logic            accept,
   input  logic            bad_seq,
   input  logic            past_end,
   output nbf_state_e      state,
   output logic [BI_W-1:0] bidx,
   output logic            req_ready,
   output logic            cap,
   output logic            fill,
   output logic            rsp_err,
   output logic            overrun
);
   localparam logic [NBF_CNT_W-1:0] ADDR_LAST = NBF_CNT_W'(ADDR_CYCLES - 1);
   localparam logic [NBF_CNT_W-1:0] WB_LAST   = NBF_CNT_W'(WB_CYCLES - 1);
   localparam logic [BI_W-1:0]      BEAT_LAST = BI_W'(BEAT_BYTES - 1);

   nbf_state_e           nxt;
   logic [NBF_CNT_W-1:0] cnt;
   logic                 off_pend;
   logic                 off_req;
   logic                 take;

   assign off_req   = sw_off | off_pend;
   assign req_ready = (state == ST_IDLE) && !sw_off;
   assign take      = accept && req_ready;
   assign cap       = (state == ST_CAP);
   assign fill      = take && (bad_seq || past_end);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RST:  nxt = ST_CMD;
         ST_CMD:  nxt = ST_ADDR;
         ST_ADDR: if (cnt == ADDR_LAST) nxt = ST_WB;
         ST_WB:   if (cnt == WB_LAST) nxt = ST_WAIT;
         ST_WAIT: begin
            if (off_req)         nxt = ST_OFF;
            else if (nand_ready) nxt = ST_IDLE;
         end
         ST_IDLE: begin
            if (off_req)   nxt = ST_OFF;
            else if (take) nxt = (bad_seq || past_end) ? ST_RSP : ST_RD;
         end
         ST_RD:   nxt = ST_CAP;
         ST_CAP:  nxt = (bidx == BEAT_LAST) ? ST_RSP : ST_RD;
         ST_RSP:  nxt = off_req ? ST_OFF : ST_IDLE;
         ST_OFF:  nxt = ST_OFF;
         default: nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_RST;
         cnt      <= '0;
         bidx     <= '0;
         off_pend <= 1'b0;
         rsp_err  <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         state <= nxt;
         if (sw_off)
            off_pend <= 1'b1;
         if ((state == ST_ADDR || state == ST_WB) && nxt == state)
            cnt <= cnt + NBF_CNT_W'(1);
         else
            cnt <= '0;
         if (state == ST_IDLE)
            bidx <= '0;
         else if (state == ST_CAP)
            bidx <= bidx + BI_W'(1);
         if (take && state == ST_IDLE) begin
            rsp_err <= bad_seq;
            if (!bad_seq && past_end)
               overrun <= 1'b1;
         end
      end
   end

   assert_wait_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_WAIT) |-> $past(nand_ready));
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   assert_off_terminal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |=> (state == ST_OFF));

endmodule

// File: rtl/nand_boot_fetcher.sv
module nand_boot_fetcher
   import nbf_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          WIN_W       = 16,
   parameter logic [15:0] WIN_BASE    = 16'h1FC0,
   parameter int          PAGE_BYTES  = 2048,
   parameter int          BEAT_BYTES  = 4,
   parameter int          ADDR_CYCLES = 4,
   parameter int          WB_CYCLES   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sw_boot_off,
   output logic                    boot_mode,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic [8*BEAT_BYTES-1:0] rsp_data,
   output logic                    rsp_err,
   output logic                    overrun,
   output logic                    nand_cle,
   output logic                    nand_ale,
   output logic                    nand_re,
   output logic [7:0]              nand_io_out,
   input  logic [7:0]              nand_io_in,
   input  logic                    nand_ready
);
   localparam int COL_W = $clog2(PAGE_BYTES + 1);
   localparam int BI_W  = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1;
   localparam int OFF_W = ADDR_W - WIN_W;

   generate
      if (PAGE_BYTES % BEAT_BYTES != 0) begin : g_bad_page
         $error("page size must be a multiple of the beat size");
      end
      if (ADDR_CYCLES < 1 || ADDR_CYCLES > 15) begin : g_bad_acyc
         $error("address cycle count out of range");
      end
      if (WB_CYCLES < 1 || WB_CYCLES > 15) begin : g_bad_wb
         $error("busy settle count out of range");
      end
      if (WIN_W > 16 || OFF_W < COL_W) begin : g_bad_win
         $error("boot window too narrow for the page");
      end
   endgenerate

   nbf_state_e       state;
   logic [COL_W-1:0] col;
   logic [BI_W-1:0]  bidx;
   logic             hit, bad_seq, past_end, cap, fill, accept;

   assign accept = req_valid && hit;

   nbf_window_decode #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE), .COL_W(COL_W)
   ) u_dec (
      .addr(req_addr), .col(col), .hit(hit), .bad_seq(bad_seq)
   );

   nbf_column_ctr #(
      .PAGE_BYTES(PAGE_BYTES), .BEAT_BYTES(BEAT_BYTES), .COL_W(COL_W)
   ) u_col (
      .clk(clk), .rst_n(rst_n), .adv(cap), .col(col), .past_end(past_end)
   );

   nbf_sequencer #(
      .ADDR_CYCLES(ADDR_CYCLES), .WB_CYCLES(WB_CYCLES),
      .BEAT_BYTES(BEAT_BYTES), .BI_W(BI_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .nand_ready(nand_ready), .sw_off(sw_boot_off),
      .accept(accept), .bad_seq(bad_seq), .past_end(past_end),
      .state(state), .bidx(bidx), .req_ready(req_ready), .cap(cap),
      .fill(fill), .rsp_err(rsp_err), .overrun(overrun)
   );

   nbf_beat_pack #(
      .BEAT_BYTES(BEAT_BYTES), .BI_W(BI_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .fill(fill), .cap(cap), .bidx(bidx),
      .din(nand_io_in), .word(rsp_data)
   );

   assign boot_mode = (state != ST_OFF);
   assign rsp_valid = (state == ST_RSP);
   assign nand_cle  = (state == ST_CMD);
   assign nand_ale  = (state == ST_ADDR);
   assign nand_re   = (state == ST_RD);

   always_comb begin
      unique case (state)
         ST_CMD:  nand_io_out = NBF_READ_CMD;
         ST_ADDR: nand_io_out = NBF_ADDR_BYTE;
         default: nand_io_out = 8'h00;
      endcase
   end

   assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nand_cle, nand_ale, nand_re}));
   assert_reject_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '1));
   assert_rsp_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_mode |-> !(nand_cle || nand_ale || nand_re || req_ready || rsp_valid));

endmodule

// File: tb/sim_nand_boot_fetcher.sv
module sim_nand_boot_fetcher;
   localparam int PAGE = 32;
   localparam int BEAT = 4;
   localparam int ACYC = 4;
   localparam int BUSY = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_boot_off = 1'b0;
   logic req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0] nand_io_in = '0;
   logic nand_ready = 1'b1;
   logic boot_mode, req_ready, rsp_valid, rsp_err, overrun;
   logic nand_cle, nand_ale, nand_re;
   logic [8*BEAT-1:0] rsp_data;
   logic [7:0] nand_io_out;

   int total = 0, bad = 0;
   int cle_n, ale_n, re_n, rsp_n, busy_left, ncol, mcol;
   bit busy_seen;
   int cyc = 0;

   always #4 clk = ~clk;

   nand_boot_fetcher #(
      .PAGE_BYTES(PAGE), .BEAT_BYTES(BEAT), .ADDR_CYCLES(ACYC), .WB_CYCLES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sw_boot_off(sw_boot_off), .boot_mode(boot_mode),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .overrun(overrun), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_re(nand_re), .nand_io_out(nand_io_out), .nand_io_in(nand_io_in),
      .nand_ready(nand_ready)
   );

   function automatic logic [7:0] page_byte(int c);
      return 8'((c * 37 + 5) & 255);
   endfunction

   function automatic logic [8*BEAT-1:0] exp_word(int c);
      logic [8*BEAT-1:0] w;
      for (int i = 0; i < BEAT; i++) w[8*i +: 8] = page_byte(c + i);
      return w;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog", 64'(cyc), 64'd100000);
         finish_run();
      end
   end

   // behavioural device model and per-clock protocol observer
   always @(negedge clk) begin
      if (rst_n) begin
         if (nand_cle) begin
            chk(cle_n == 0 && ale_n == 0, "R1/R6 cle order", 64'(cle_n), 64'd0);
            chk(nand_io_out == 8'h00, "R1 cmd byte", 64'(nand_io_out), 64'h00);
            cle_n++;
         end
         if (nand_ale) begin
            chk(cle_n == 1 && ale_n < ACYC, "R1/R6 ale order", 64'(ale_n), 64'(ACYC));
            chk(nand_io_out == 8'h00, "R1 addr byte", 64'(nand_io_out), 64'h00);
            ale_n++;
            if (ale_n == ACYC) begin
               nand_ready = 1'b0;
               busy_left  = BUSY;
               busy_seen  = 1'b1;
            end
         end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) nand_ready = 1'b1;
         end
         if (!nand_ready && (req_ready || nand_re))
            chk(1'b0, "R2 activity while busy", {62'd0, req_ready, nand_re}, 64'd0);
         if (nand_re) begin
            chk(ale_n == ACYC && ncol < PAGE, "R6 read column", 64'(ncol), 64'(PAGE));
            nand_io_in = page_byte(ncol);
            ncol++;
            re_n++;
         end
         if (!boot_mode && (nand_cle || nand_ale || nand_re || req_ready || rsp_valid))
            chk(1'b0, "R9 activity after off", 64'd1, 64'd0);
         if (rsp_valid) rsp_n++;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      sw_boot_off = 1'b0;
      nand_ready = 1'b1;
      cle_n = 0; ale_n = 0; re_n = 0; rsp_n = 0; busy_left = 0;
      ncol = 0; mcol = 0; busy_seen = 1'b0;
      repeat (3) @(negedge clk);
      chk(boot_mode && !req_ready && !rsp_valid, "R9 reset state",
          {61'd0, boot_mode, req_ready, rsp_valid}, 64'b100);
      chk(!(nand_cle || nand_ale || nand_re), "R1 no strobe in reset",
          {61'd0, nand_cle, nand_ale, nand_re}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nand_cle, "R1 cle after release", 64'(nand_cle), 64'd1);
   endtask

   task automatic wait_ready();
      for (int n = 0; n < 200 && !req_ready; n++) @(negedge clk);
   endtask

   task automatic do_req(input logic [31:0] a, input logic [8*BEAT-1:0] ed,
                         input bit eerr, input int elat, input int ere,
                         input bit off_mid, input string rq);
      int lat, re0;
      wait_ready();
      re0 = re_n;
      req_valid = 1'b1;
      req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      if (off_mid) sw_boot_off = 1'b1;
      while (!rsp_valid && lat < 60) begin
         @(negedge clk);
         sw_boot_off = 1'b0;
         lat++;
      end
      sw_boot_off = 1'b0;
      chk(rsp_valid, {rq, " valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_data == ed, {rq, " data"}, 64'(rsp_data), 64'(ed));
      chk(rsp_err == eerr, {rq, " err"}, 64'(rsp_err), 64'(eerr));
      chk(lat == elat, "R8 latency", 64'(lat), 64'(elat));
      chk(re_n - re0 == ere, {rq, " read strobes"}, 64'(re_n - re0), 64'(ere));
      chk(!req_ready, "R8 ready low in rsp", 64'(req_ready), 64'd0);
   endtask

   task automatic ignored_req(input logic [31:0] a);
      int r0, e0;
      wait_ready();
      r0 = rsp_n;
      e0 = re_n;
      req_valid = 1'b1;
      req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(rsp_n == r0 && re_n == e0, "R3 no response outside window",
          64'(rsp_n - r0 + re_n - e0), 64'd0);
   endtask

   initial begin
      // phase A: full page with rejections and overrun
      do_reset();
      wait_ready();
      chk(busy_seen, "R2 busy observed", 64'(busy_seen), 64'd1);
      chk(cle_n == 1 && ale_n == ACYC && re_n == 0, "R1 init sequence",
          64'(cle_n * 16 + ale_n), 64'(16 + ACYC));
      ignored_req(32'h1FC1_0000);
      ignored_req(32'h0FC0_0000);
      do_req(32'h1FC0_0000, exp_word(0), 1'b0, 1 + 2*BEAT, BEAT, 1'b0, "R4 first");
      mcol = BEAT;
      do_req(32'h1FC0_0000 + 32'(mcol + BEAT), '1, 1'b1, 1, 0, 1'b0, "R5 skip ahead");
      do_req(32'h1FC0_0000, '1, 1'b1, 1, 0, 1'b0, "R5 replay");
      while (mcol < PAGE) begin
         do_req(32'h1FC0_0000 + 32'(mcol), exp_word(mcol), 1'b0, 1 + 2*BEAT, BEAT,
                1'b0, "R4 sequential");
         mcol += BEAT;
      end
      chk(cle_n == 1 && ale_n == ACYC && ncol == PAGE, "R6 single page",
          64'(ncol), 64'(PAGE));
      chk(!overrun, "R7 no overrun yet", 64'(overrun), 64'd0);
      do_req(32'h1FC0_0000 + 32'(PAGE), '1, 1'b0, 1, 0, 1'b0, "R7 past end");
      @(negedge clk);
      chk(overrun, "R7 overrun set", 64'(overrun), 64'd1);
      do_req(32'h1FC0_0000 + 32'(PAGE), '1, 1'b0, 1, 0, 1'b0, "R7 again");
      chk(overrun && ncol == PAGE, "R7 overrun sticky", 64'(overrun), 64'd1);

      // phase B: end boot during a fetch
      do_reset();
      wait_ready();
      chk(cle_n == 1 && ale_n == ACYC, "R1 init after second reset",
          64'(ale_n), 64'(ACYC));
      do_req(32'h1FC0_0000, exp_word(0), 1'b0, 1 + 2*BEAT, BEAT, 1'b1, "R10 fetch");
      chk(boot_mode, "R10 mode held in rsp", 64'(boot_mode), 64'd1);
      @(negedge clk);
      chk(!boot_mode, "R10 mode falls", 64'(boot_mode), 64'd0);
      req_valid = 1'b1;
      req_addr = 32'h1FC0_0000 + 32'(BEAT);
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
      chk(!boot_mode && rsp_n == 1 && re_n == BEAT, "R9 quiet after off",
          64'(rsp_n), 64'd1);
      finish_run();
   end

endmodule